// File: doc/BRIEF.md
# Programmable Interval Timer

This peripheral counts down a 32-bit value once per tick pulse. The tick pulse is a clock enable produced by a prescaler outside the block. Software reaches the timer through a word-addressed register window of 4 KB. It can load a reload limit, overwrite or read the live count, start and stop counting, and choose between periodic reload and single-shot operation. Two read-only words let software identify the device and learn the tick rate.

When the count runs out, the block sets a sticky status bit. A one-shot run also stops itself at that point. The interrupt line is the status bit masked by an enable bit. Software clears the status by writing a one to it.

Top module: `ivl_timer`

## Requirements
- R1: After reset the running, mode, limit, count, enable and status words all read zero, and `irq` is low.
- R2: The register index is `bus_addr[11:2]`, and `bus_addr[1:0]` is ignored. The indices are: 0 identifier (reads `DEV_ID`), 1 running flag, 2 mode flag (1 = one-shot), 3 limit, 4 count, 5 interrupt enable, 6 interrupt status, 7 tick rate (reads `TICK_HZ`). Indices 0 and 7 ignore writes.
- R3: Any index above 7 reads zero, and a write to it changes no register.
- R4: While running, each tick decrements the count. A tick that takes the count from 1 to 0 is an expiry, and it sets the status bit (bit 0 of index 6). While stopped, the count holds.
- R5: A tick at count zero reloads the limit and is not an expiry. In periodic mode, expiries are therefore spaced limit+1 ticks apart, and a limit of zero never expires.
- R6: In one-shot mode an expiry clears the running flag, and the count then stays at zero.
- R7: A limit write stores the limit and also loads the count with it. A count write replaces only the count. Either write overrides a tick in the same cycle.
- R8: Writing the running flag with the value it already holds changes nothing. Changing the mode while running keeps the current count, and counting continues under the new mode.
- R9: `irq` is high exactly when the status and enable bits (bit 0 of each) are both set. It follows a write or an expiry on the next cycle.
- R10: A status write clears the status bit when bit 0 of the written value is 1 and leaves it unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled tick pulse, one cycle wide |
| bus_addr | input | 12 | Byte address within the register window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take for granted that a write never lands in the same cycle as an expiry it would contend with. They also assume that `bus_we` is low whenever they predict the count from a tick alone, since a count or limit write takes priority over the tick. The bench drives bus accesses and tick pulses from a single sequential process, one operation at a time, so no bus write ever meets a tick in the same cycle. Periodic spacing is swept over limits 0 to 6 and one-shot stopping over limits 1 to 4, and every expected tick count is computed as limit or limit+1.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    localparam int ADDR_W = 12;
    localparam int IDX_W  = ADDR_W - 2;

    typedef logic [IDX_W-1:0] idx_t;

    localparam idx_t IDX_ID   = idx_t'(0);
    localparam idx_t IDX_RUN  = idx_t'(1);
    localparam idx_t IDX_MODE = idx_t'(2);
    localparam idx_t IDX_LIM  = idx_t'(3);
    localparam idx_t IDX_CNT  = idx_t'(4);
    localparam idx_t IDX_IEN  = idx_t'(5);
    localparam idx_t IDX_STS  = idx_t'(6);
    localparam idx_t IDX_FREQ = idx_t'(7);

    // one strobe per writable register
    typedef struct packed {
        logic run;
        logic mode;
        logic lim;
        logic cnt;
        logic ien;
        logic sts;
    } wr_sel_t;

    function automatic wr_sel_t decode_write(input logic we, input idx_t idx);
        wr_sel_t s;
        s.run  = we && (idx == IDX_RUN);
        s.mode = we && (idx == IDX_MODE);
        s.lim  = we && (idx == IDX_LIM);
        s.cnt  = we && (idx == IDX_CNT);
        s.ien  = we && (idx == IDX_IEN);
        s.sts  = we && (idx == IDX_STS);
        return s;
    endfunction

endpackage

// File: rtl/ivl_timer_decode.sv
module ivl_timer_decode
    import ivl_timer_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    output idx_t              idx,
    output wr_sel_t           wsel
);
    assign idx  = bus_addr[ADDR_W-1:2];
    assign wsel = decode_write(bus_we, idx);
endmodule

// File: rtl/ivl_timer_core.sv
module ivl_timer_core
    import ivl_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  wr_sel_t           wsel,
    input  logic [DATA_W-1:0] wdata,
    output logic              run_q,
    output logic              os_q,
    output logic [DATA_W-1:0] lim_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic              expire
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic cnt_wr, step, at_zero;

    assign cnt_wr  = wsel.lim | wsel.cnt;
    assign step    = tick_en & run_q & ~cnt_wr;
    assign at_zero = (cnt_q == '0);
    assign expire  = step & (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            os_q  <= 1'b0;
            lim_q <= '0;
            cnt_q <= '0;
        end else begin
            if (wsel.run)
                run_q <= wdata[0];
            else if (expire && os_q)
                run_q <= 1'b0;

            if (wsel.mode)
                os_q <= wdata[0];

            if (wsel.lim)
                lim_q <= wdata;

            if (cnt_wr)
                cnt_q <= wdata;
            else if (step)
                cnt_q <= at_zero ? lim_q : cnt_q - ONE;
        end
    end
endmodule

// File: rtl/ivl_timer_irq.sv
module ivl_timer_irq
    import ivl_timer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    expire,
    input  wr_sel_t wsel,
    input  logic    wbit,
    output logic    ien_q,
    output logic    sts_q,
    output logic    irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= 1'b0;
            sts_q <= 1'b0;
        end else begin
            if (wsel.ien)
                ien_q <= wbit;
            // a new expiry outranks a clear in the same cycle
            if (expire)
                sts_q <= 1'b1;
            else if (wsel.sts && wbit)
                sts_q <= 1'b0;
        end
    end

    assign irq = sts_q & ien_q;
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int              DATA_W  = 32,
    parameter logic [31:0]     DEV_ID  = 32'h7100_0003,
    parameter logic [31:0]     TICK_HZ = 32'd1_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [11:0]       bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    idx_t              idx;
    wr_sel_t           wsel;
    logic              run_q, os_q, ien_q, sts_q, expire;
    logic [DATA_W-1:0] lim_q, cnt_q;

    ivl_timer_decode u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .idx      (idx),
        .wsel     (wsel)
    );

    ivl_timer_core #(.DATA_W(DATA_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wsel    (wsel),
        .wdata   (bus_wdata),
        .run_q   (run_q),
        .os_q    (os_q),
        .lim_q   (lim_q),
        .cnt_q   (cnt_q),
        .expire  (expire)
    );

    ivl_timer_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .wsel   (wsel),
        .wbit   (bus_wdata[0]),
        .ien_q  (ien_q),
        .sts_q  (sts_q),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_ID:   bus_rdata = DATA_W'(DEV_ID);
            IDX_RUN:  bus_rdata = DATA_W'(run_q);
            IDX_MODE: bus_rdata = DATA_W'(os_q);
            IDX_LIM:  bus_rdata = lim_q;
            IDX_CNT:  bus_rdata = cnt_q;
            IDX_IEN:  bus_rdata = DATA_W'(ien_q);
            IDX_STS:  bus_rdata = DATA_W'(sts_q);
            IDX_FREQ: bus_rdata = DATA_W'(TICK_HZ);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [11:0]       bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              run_q,
    input logic              os_q,
    input logic              sts_q,
    input logic [DATA_W-1:0] lim_q,
    input logic [DATA_W-1:0] cnt_q,
    input logic              expire
);
    logic [9:0] cidx;
    assign cidx = bus_addr[11:2];

    // R4
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && run_q && !bus_we && cnt_q > DATA_W'(1)) |=> cnt_q == $past(cnt_q) - DATA_W'(1));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !bus_we) |=> $stable(cnt_q));

    // R4
    expire_sts_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> sts_q);

    // R5
    zero_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && run_q && !bus_we && cnt_q == '0) |=> cnt_q == $past(lim_q));

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && os_q && !(bus_we && cidx == 10'd1)) |=> !run_q);

    // R7
    lim_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && cidx == 10'd3) |=> cnt_q == $past(bus_wdata));

    // R10
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && cidx == 10'd6 && bus_wdata[0] && !expire) |=> !irq);

    // R3
    undef_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (cidx > 10'd7) |-> bus_rdata == '0);
endmodule

bind ivl_timer ivl_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .run_q     (run_q),
    .os_q      (os_q),
    .sts_q     (sts_q),
    .lim_q     (lim_q),
    .cnt_q     (cnt_q),
    .expire    (expire)
);

// File: tb/tb_ivl_timer.sv
module tb_ivl_timer;
    localparam logic [31:0] DEV_ID  = 32'h7100_0003;
    localparam logic [31:0] TICK_HZ = 32'd1_000_000;

    localparam logic [9:0] I_ID = 0, I_RUN = 1, I_MODE = 2, I_LIM = 3,
                           I_CNT = 4, I_IEN = 5, I_STS = 6, I_FREQ = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    ivl_timer dut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_addr = {idx, 2'b00}; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_raw(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic rd(input logic [9:0] idx, output logic [31:0] d);
        rd_raw({idx, 2'b00}, d);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    // ticks until status sets; 0 if it never does within maxn
    task automatic to_expiry(input int maxn, output int n);
        logic [31:0] s;
        n = 0;
        for (int k = 1; k <= maxn; k++) begin
            tick(1);
            rd(I_STS, s);
            if (s[0]) begin n = k; break; end
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 1; i <= 6; i++) begin
            rd(10'(i), d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 reset irq", 32'(irq), 32'h0);

        // R2 fixed words, alias of low address bits, read-only
        rd(I_ID, d);   check("R2 id", d, DEV_ID);
        rd(I_FREQ, d); check("R2 freq", d, TICK_HZ);
        wr(I_ID, 32'h5); wr(I_FREQ, 32'h9);
        rd(I_ID, d);   check("R2 id read-only", d, DEV_ID);
        rd(I_FREQ, d); check("R2 freq read-only", d, TICK_HZ);
        wr(I_LIM, 32'd44);
        rd_raw({I_LIM, 2'b11}, d); check("R2 low address bits ignored", d, 32'd44);

        // R3 undefined indices
        foreach (d[i]) if (i < 3) begin
            logic [9:0] u;
            u = (i == 0) ? 10'd8 : (i == 1) ? 10'd100 : 10'd1023;
            rd(u, d); check("R3 undefined read", d, 32'h0);
            wr(u, 32'hFFFF_FFFF);
        end
        rd(I_LIM, d); check("R3 undefined write keeps limit", d, 32'd44);
        rd(I_CNT, d); check("R3 undefined write keeps count", d, 32'd44);
        rd(I_RUN, d); check("R3 undefined write keeps running", d, 32'h0);
        rd(I_IEN, d); check("R3 undefined write keeps enable", d, 32'h0);

        // R5 periodic spacing sweep, R4 expiry sets status
        for (int L = 1; L <= 6; L++) begin
            wr(I_RUN, 0); wr(I_MODE, 0); wr(I_STS, 1);
            wr(I_LIM, 32'(L)); wr(I_RUN, 1);
            to_expiry(L + 3, n); check("R4 first expiry after limit ticks", 32'(n), 32'(L));
            rd(I_CNT, d); check("R4 count zero at expiry", d, 32'h0);
            for (int r = 0; r < 2; r++) begin
                wr(I_STS, 1);
                to_expiry(L + 4, n); check("R5 periodic spacing limit+1", 32'(n), 32'(L + 1));
            end
        end

        // R5 limit zero never expires
        wr(I_RUN, 0); wr(I_STS, 1); wr(I_LIM, 0); wr(I_RUN, 1);
        to_expiry(8, n); check("R5 zero limit no expiry", 32'(n), 32'h0);
        rd(I_CNT, d);    check("R5 zero limit count", d, 32'h0);

        // R6 one-shot auto stop
        for (int L = 1; L <= 4; L++) begin
            wr(I_RUN, 0); wr(I_MODE, 1); wr(I_STS, 1);
            wr(I_LIM, 32'(L)); wr(I_RUN, 1);
            to_expiry(L + 3, n); check("R6 one-shot expiry ticks", 32'(n), 32'(L));
            rd(I_RUN, d); check("R6 running cleared", d, 32'h0);
            tick(3);
            rd(I_CNT, d); check("R6 count stays zero", d, 32'h0);
        end

        // R8 rewrite running, mode change keeps count
        wr(I_RUN, 0); wr(I_MODE, 0); wr(I_STS, 1); wr(I_LIM, 10); wr(I_RUN, 1);
        tick(3);
        rd(I_CNT, d); check("R4 decrement by ticks", d, 32'd7);
        wr(I_RUN, 1);
        rd(I_CNT, d); check("R8 same running write no effect", d, 32'd7);
        rd(I_RUN, d); check("R8 still running", d, 32'd1);
        tick(1);
        wr(I_MODE, 1);
        rd(I_CNT, d); check("R8 mode change keeps count", d, 32'd6);
        to_expiry(10, n); check("R8 new mode continues", 32'(n), 32'd6);
        rd(I_RUN, d); check("R8 one-shot after switch stops", d, 32'h0);

        // R4 stop freezes, R7 writes
        wr(I_MODE, 0); wr(I_LIM, 9); wr(I_RUN, 1);
        tick(2);
        wr(I_RUN, 0);
        tick(3);
        rd(I_CNT, d); check("R4 stopped count holds", d, 32'd7);
        wr(I_RUN, 0);
        rd(I_CNT, d); check("R8 repeated stop no effect", d, 32'd7);
        wr(I_CNT, 3);
        rd(I_CNT, d); check("R7 count write", d, 32'd3);
        rd(I_LIM, d); check("R7 count write keeps limit", d, 32'd9);
        wr(I_LIM, 12);
        rd(I_CNT, d); check("R7 limit write reloads count", d, 32'd12);

        // R9 masking, R10 write-one-to-clear
        wr(I_RUN, 0); wr(I_STS, 1); wr(I_IEN, 0); wr(I_LIM, 2); wr(I_RUN, 1);
        tick(2);
        rd(I_STS, d); check("R4 status set", d, 32'd1);
        check("R9 masked irq low", 32'(irq), 32'h0);
        wr(I_IEN, 1);
        #1 check("R9 enabled irq high", 32'(irq), 32'd1);
        wr(I_STS, 32'hFFFF_FFFE);
        #1 check("R10 zero bit leaves irq", 32'(irq), 32'd1);
        rd(I_STS, d); check("R10 zero bit leaves status", d, 32'd1);
        wr(I_STS, 1);
        #1 check("R10 clear drops irq", 32'(irq), 32'h0);
        rd(I_STS, d); check("R10 status cleared", d, 32'h0);
        tick(3);
        check("R9 expiry raises irq", 32'(irq), 32'd1);
        wr(I_IEN, 0);
        #1 check("R9 disable lowers irq", 32'(irq), 32'h0);

        summary();
        $finish;
    end
endmodule